// File: doc/BRIEF.md
# Dual-Mode Multi-Precision Multiply-Accumulate Element

This block is the arithmetic core of a two-stage decimating filter. It has one bank of eight small multipliers. Each multiplier takes a 3-bit slice of a packed 24-bit data word and a 13-bit two's-complement coefficient. The same multipliers serve two operand widths, chosen each cycle by a mode input.

In narrow mode every slice is an independent unsigned 3-bit sample. Each slice is multiplied by its own lane coefficient, and the eight products are summed with no shift, so eight multiply-accumulates complete per cycle. In wide mode the 24-bit word is one signed sample. Every lane uses the lane-0 coefficient, and lane i's product is weighted by 2^(3i), so the tree forms one full coefficient × sample product per cycle.

The partial products are never sign-extended. Each lane inverts the sign bit of its 16-bit product, and a fixed compensation constant for the selected mode is added once in the tree. The sum goes into a 34-bit accumulator. That accumulator can either start a new convolution or add to the running total.

Top module: `mpmac_core`

## Requirements
- R1: With `wide_mode`=0, a step with `acc_en`=1 adds the sum over lanes i=0..7 of unsigned `data_in[3i+2:3i]` (0..7) times signed `coef_in[13i+12:13i]`.
- R2: With `wide_mode`=1, a step adds signed `data_in` (bit 23 is the sign) times signed `coef_in[12:0]`. The coefficients of lanes 1..7 have no effect on the result.
- R3: `acc_en`=1 with `acc_clr`=1 loads the accumulator with the current step's sum and discards the old value. This takes no extra cycle.
- R4: With `acc_en`=0 the accumulator holds its value, whatever `acc_clr`, `wide_mode`, `data_in` and `coef_in` are.
- R5: The accumulator is 34 bits wide and works modulo 2^34. A step with `acc_en`=1 and `acc_clr`=0 adds the sum to the old value, and `acc_out` shows the result after the next rising clock edge.
- R6: While `rst_n` is low, `acc_out` is zero. After `rst_n` rises, the accumulator stays zero for two more clock edges.
- R7: Lane i pairs data slice i with coefficient field i. A single nonzero lane gives exactly that lane's product.
- R8: Extreme operands are exact. Coefficient -4096 times sample 7 in every lane, and -4096 times the largest and smallest 24-bit samples, give the correct 34-bit results.
- R9: An all-zero data word adds zero in both modes, so the compensation constant exactly cancels the inverted sign bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wide_mode | input | 1 | 0: eight 3-bit MACs; 1: one 24-bit MAC |
| acc_clr | input | 1 | With `acc_en`, load the sum instead of adding it |
| acc_en | input | 1 | Update the accumulator this cycle |
| data_in | input | 24 | Packed data: eight 3-bit slices, slice i at bits 3i+2:3i |
| coef_in | input | 104 | Eight 13-bit signed coefficients, lane i at bits 13i+12:13i |
| acc_out | output | 34 | Accumulator value |

## Verification
The bound assertions check the accumulator's behaviour on every cycle:
- it holds while disabled;
- a clear loads exactly the tree sum;
- an accumulate adds the tree sum modulo 2^34;
- a zero data word gives a zero sum in either mode, which tests the compensation constant.

The assertions cannot show that the tree sum is the right arithmetic product. The bench scenarios show that:
- lane ordering and the unsigned treatment of narrow samples;
- the signed top slice and the lane-0 coefficient broadcast in wide mode;
- extreme negative coefficients and 34-bit wrap-around;
- the reset values.

// File: rtl/mpmac_pkg.sv
package mpmac_pkg;

  localparam int unsigned LANES_DEF  = 8;
  localparam int unsigned SLICE_DEF  = 3;
  localparam int unsigned COEF_DEF   = 13;
  localparam int unsigned ACC_DEF    = 34;

  // Sum of the sign-bit weights that the inverted sign bits add across all
  // lanes; step is the per-lane shift (0 in narrow mode).
  function automatic logic [63:0] bias_total(int unsigned lanes,
                                             int unsigned step,
                                             int unsigned ppw);
    logic [63:0] acc;
    acc = '0;
    for (int unsigned i = 0; i < lanes; i++) begin
      acc = acc + (64'd1 << (ppw - 1 + step * i));
    end
    return acc;
  endfunction

endpackage

// File: rtl/mpmac_lane.sv
module mpmac_lane #(
  parameter int unsigned SLICE_W = 3,
  parameter int unsigned COEF_W  = 13,
  localparam int unsigned PP_W   = SLICE_W + COEF_W
) (
  input  logic [SLICE_W-1:0] slice,
  input  logic [COEF_W-1:0]  coef,
  input  logic               slice_signed,
  output logic [PP_W-1:0]    pp_biased
);

  logic signed [SLICE_W:0]  d_ext;
  logic signed [PP_W-1:0]   prod;

  always_comb begin
    d_ext     = slice_signed ? $signed({slice[SLICE_W-1], slice})
                             : $signed({1'b0, slice});
    prod      = d_ext * $signed(coef);
    // Inverted sign bit: value becomes prod + 2^(PP_W-1), always non-negative
    pp_biased = {~prod[PP_W-1], prod[PP_W-2:0]};
  end

endmodule

// File: rtl/mpmac_tree.sv
module mpmac_tree #(
  parameter int unsigned LANES   = 8,
  parameter int unsigned SLICE_W = 3,
  parameter int unsigned PP_W    = 16,
  parameter int unsigned ACC_W   = 34
) (
  input  logic                  wide_mode,
  input  logic [LANES*PP_W-1:0] pp_bus,
  output logic [ACC_W-1:0]      sum
);

  localparam logic [63:0] BIAS_N = mpmac_pkg::bias_total(LANES, 0, PP_W);
  localparam logic [63:0] BIAS_W = mpmac_pkg::bias_total(LANES, SLICE_W, PP_W);
  localparam logic [ACC_W-1:0] COMP_N = ACC_W'(~BIAS_N + 64'd1);
  localparam logic [ACC_W-1:0] COMP_W = ACC_W'(~BIAS_W + 64'd1);

  logic [ACC_W-1:0] term [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_term
    logic [ACC_W-1:0] ext;
    assign ext     = ACC_W'(pp_bus[i*PP_W +: PP_W]);
    assign term[i] = wide_mode ? (ext << (SLICE_W * i)) : ext;
  end

  always_comb begin
    sum = wide_mode ? COMP_W : COMP_N;
    for (int i = 0; i < LANES; i++) begin
      sum = sum + term[i];
    end
  end

endmodule

// File: rtl/mpmac_acc.sv
module mpmac_acc #(
  parameter int unsigned ACC_W = 34
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic             acc_en,
  input  logic             acc_clr,
  input  logic [ACC_W-1:0] sum,
  output logic [ACC_W-1:0] acc_q
);

  logic [ACC_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (acc_en) begin
      acc_d = acc_clr ? sum : (acc_q + sum);
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) acc_q <= '0;
    else        acc_q <= acc_d;
  end

endmodule

// File: rtl/mpmac_core.sv
module mpmac_core #(
  parameter int unsigned LANES   = mpmac_pkg::LANES_DEF,
  parameter int unsigned SLICE_W = mpmac_pkg::SLICE_DEF,
  parameter int unsigned COEF_W  = mpmac_pkg::COEF_DEF,
  parameter int unsigned ACC_W   = mpmac_pkg::ACC_DEF,
  localparam int unsigned DATA_W = LANES * SLICE_W,
  localparam int unsigned PP_W   = SLICE_W + COEF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wide_mode,
  input  logic                    acc_clr,
  input  logic                    acc_en,
  input  logic [DATA_W-1:0]       data_in,
  input  logic [LANES*COEF_W-1:0] coef_in,
  output logic [ACC_W-1:0]        acc_out
);

  // Reset: asserted asynchronously, released after two clock edges
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic [LANES*PP_W-1:0] pp_bus;
  logic [ACC_W-1:0]      tree_sum;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [COEF_W-1:0] lane_coef;
    // Wide mode broadcasts the lane-0 coefficient to every lane
    assign lane_coef = wide_mode ? coef_in[COEF_W-1:0]
                                 : coef_in[i*COEF_W +: COEF_W];
    mpmac_lane #(
      .SLICE_W (SLICE_W),
      .COEF_W  (COEF_W)
    ) u_lane (
      .slice        (data_in[i*SLICE_W +: SLICE_W]),
      .coef         (lane_coef),
      .slice_signed (wide_mode && (i == LANES - 1)),
      .pp_biased    (pp_bus[i*PP_W +: PP_W])
    );
  end

  mpmac_tree #(
    .LANES   (LANES),
    .SLICE_W (SLICE_W),
    .PP_W    (PP_W),
    .ACC_W   (ACC_W)
  ) u_tree (
    .wide_mode (wide_mode),
    .pp_bus    (pp_bus),
    .sum       (tree_sum)
  );

  mpmac_acc #(
    .ACC_W (ACC_W)
  ) u_acc (
    .clk     (clk),
    .rst_q   (rst_q),
    .acc_en  (acc_en),
    .acc_clr (acc_clr),
    .sum     (tree_sum),
    .acc_q   (acc_out)
  );

endmodule

// File: rtl/mpmac_chk.sv
module mpmac_chk #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned ACC_W  = 34
) (
  input logic              clk,
  input logic              rst_q,
  input logic              acc_en,
  input logic              acc_clr,
  input logic [DATA_W-1:0] data_in,
  input logic [ACC_W-1:0]  tree_sum,
  input logic [ACC_W-1:0]  acc_out
);

  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_q)
    !acc_en |=> $stable(acc_out));

  assert_clear_loads_sum_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_en && acc_clr) |=> (acc_out == $past(tree_sum)));

  assert_wrap_accumulate_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_en && !acc_clr) |=> (acc_out == ACC_W'($past(acc_out) + $past(tree_sum))));

  assert_zero_data_zero_sum_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_en && acc_clr && (data_in == '0)) |=> (acc_out == '0));

endmodule

bind mpmac_core mpmac_chk #(
  .DATA_W (DATA_W),
  .ACC_W  (ACC_W)
) u_mpmac_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .acc_en   (acc_en),
  .acc_clr  (acc_clr),
  .data_in  (data_in),
  .tree_sum (tree_sum),
  .acc_out  (acc_out)
);

// File: tb/test_mpmac_core.sv
`timescale 1ns/1ps
module test_mpmac_core;

  localparam int LANES = 8;
  localparam int SW    = 3;
  localparam int CW    = 13;
  localparam int AW    = 34;
  localparam int DW    = LANES * SW;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wide_mode;
  logic            acc_clr;
  logic            acc_en;
  logic [DW-1:0]   data_in;
  logic [LANES*CW-1:0] coef_in;
  logic [AW-1:0]   acc_out;

  int total = 0;
  int bad   = 0;
  logic [AW-1:0] model;
  logic          finished = 1'b0;

  always #2.5 clk = ~clk;

  mpmac_core i_mpmac_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_mode (wide_mode),
    .acc_clr   (acc_clr),
    .acc_en    (acc_en),
    .data_in   (data_in),
    .coef_in   (coef_in),
    .acc_out   (acc_out)
  );

  function automatic longint lane_c(logic [LANES*CW-1:0] c, int i);
    logic signed [CW-1:0] v;
    v = c[i*CW +: CW];
    return longint'(v);
  endfunction

  function automatic logic [AW-1:0] step_sum(logic w, logic [DW-1:0] d,
                                             logic [LANES*CW-1:0] c);
    longint s;
    logic signed [DW-1:0] sd;
    s = 0;
    if (w) begin
      sd = d;
      s  = longint'(sd) * lane_c(c, 0);
    end else begin
      for (int i = 0; i < LANES; i++) begin
        s += longint'(d[i*SW +: SW]) * lane_c(c, i);
      end
    end
    return AW'(s);
  endfunction

  function automatic logic [LANES*CW-1:0] all_coef(logic [CW-1:0] v);
    logic [LANES*CW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*CW +: CW] = v;
    return r;
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: acc_out=%h expected=%h", tag, act, exp);
    end
  endtask

  // One step: drive at negedge, update model, check after the next rising edge
  task automatic step(string tag, logic w, logic clr, logic en,
                      logic [DW-1:0] d, logic [LANES*CW-1:0] c);
    @(negedge clk);
    wide_mode = w; acc_clr = clr; acc_en = en; data_in = d; coef_in = c;
    if (en) model = clr ? step_sum(w, d, c) : AW'(model + step_sum(w, d, c));
    @(posedge clk);
    #1;
    check(tag, acc_out, model);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; acc_en = 1'b0; acc_clr = 1'b0;
    #1;
    model = '0;
    check("R6 reset", acc_out, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // two synchroniser edges during which enable must not change the value
    acc_en = 1'b1; acc_clr = 1'b1; wide_mode = 1'b0;
    data_in = '1; coef_in = all_coef(13'd100);
    repeat (2) @(posedge clk);
    #1;
    check("R6 held after release", acc_out, '0);
    @(negedge clk);
    acc_en = 1'b0;
    @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [LANES*CW-1:0] c;
    logic [DW-1:0]       d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wide_mode = 1'b0; acc_clr = 1'b0; acc_en = 1'b0;
    data_in = '0; coef_in = '0; model = '0;
    do_reset();

    // R7: one lane at a time
    for (int i = 0; i < LANES; i++) begin
      c = '0; c[i*CW +: CW] = CW'(i * 37 + 5);
      d = '0; d[i*SW +: SW] = SW'(i % 7 + 1);
      step("R7 single lane", 1'b0, 1'b1, 1'b1, d, c);
    end
    // R8: extreme negative coefficient, maximum samples, narrow
    step("R8 narrow -4096x7", 1'b0, 1'b1, 1'b1, '1, all_coef(13'h1000));
    // R1: unsigned treatment of 7 (not -1)
    step("R1 narrow unsigned", 1'b0, 1'b1, 1'b1, '1, all_coef(13'd1));
    // R9: zero data in both modes
    step("R9 zero narrow", 1'b0, 1'b1, 1'b1, '0, all_coef(13'h1000));
    step("R9 zero wide", 1'b1, 1'b1, 1'b1, '0, all_coef(13'h1000));
    // R2: wide extremes and signed top slice
    step("R8 wide min*neg", 1'b1, 1'b1, 1'b1, 24'h800000, all_coef(13'h1000));
    step("R8 wide max*neg", 1'b1, 1'b1, 1'b1, 24'h7FFFFF, all_coef(13'h1000));
    step("R2 wide -1", 1'b1, 1'b1, 1'b1, 24'hFFFFFF, all_coef(13'd1234));
    // R2: lanes 1..7 coefficients ignored in wide mode
    c = {91'h5A5A5A5A5A5A5A5A5A5A5A, 13'd77};
    step("R2 other lanes ignored", 1'b1, 1'b1, 1'b1, 24'h123456, c);
    c[CW-1:0] = 13'd77; c[LANES*CW-1:CW] = '0;
    step("R2 lane0 only", 1'b1, 1'b1, 1'b1, 24'h123456, c);
    // R5: repeated accumulation with wrap
    for (int k = 0; k < 6; k++)
      step("R5 wrap accumulate", 1'b1, 1'b0, 1'b1, 24'h7FFFFF, all_coef(13'h1000));
    // R4: disabled, clear and inputs toggling
    step("R4 hold clr", 1'b0, 1'b1, 1'b0, '1, all_coef(13'd999));
    step("R4 hold wide", 1'b1, 1'b0, 1'b0, 24'h654321, all_coef(13'h1ABC));
    // R3: clear back-to-back with accumulate
    step("R3 clear", 1'b0, 1'b1, 1'b1, 24'hABCDEF, all_coef(13'd11));
    step("R5 accumulate after clear", 1'b0, 1'b0, 1'b1, 24'h13579B, all_coef(13'h1F00));

    // Random mixture
    for (int n = 0; n < 600; n++) begin
      logic w, clr, en;
      w   = 1'($urandom());
      clr = ($urandom() % 8) == 0;
      en  = ($urandom() % 6) != 0;
      d   = DW'($urandom());
      for (int i = 0; i < LANES; i++) c[i*CW +: CW] = CW'($urandom());
      if (!en)       step("R4 random hold", w, clr, en, d, c);
      else if (clr)  step("R3 random clear", w, clr, en, d, c);
      else if (w)    step("R2 random wide", w, clr, en, d, c);
      else           step("R1 random narrow", w, clr, en, d, c);
    end

    // Reset in the middle of activity
    step("R5 before reset", 1'b1, 1'b0, 1'b1, 24'h3FFFFF, all_coef(13'd4095));
    do_reset();
    step("R1 after reset", 1'b0, 1'b0, 1'b1, 24'h000007, all_coef(13'd3));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule